// File: doc/BRIEF.md
# Serial TDM Timeslot Link

This block is the far end of one time-division-multiplexed serial link. It runs from a 16.384 MHz serial clock. From that clock it makes an active-low frame sync that both directions share. A frame holds 128 timeslots of 8 bits each, which is 1024 bits, or 125 µs at 8.192 Mbps. A static mode input chooses the clocking. In single-rate clocking each bit lasts one clock. In double-rate clocking each bit lasts two clocks. The block reads the mode input only when one frame ends and the next begins.

On the transmit side, the block takes one byte per timeslot through a valid/ready handshake. It sends the byte MSB first and launches each bit on the falling clock edge. If no byte is offered when a timeslot is due, the block sends all-ones for that timeslot and sets a sticky underrun flag. On the receive side, the block samples the serial input on the rising edge that closes each bit. It reports each completed byte together with the index of the timeslot it came from. A loopback from the transmit pin to the receive pin therefore returns the transmitted stream, each byte tagged with its slot.

Top module: `tdm_link`

## Requirements
- R1: In single-rate clocking (`mode_dbl`=0) the interval between consecutive frame-sync pulses is 1024 clocks.
- R2: In double-rate clocking (`mode_dbl`=1) the interval between consecutive frame-sync pulses is 2048 clocks.
- R3: `fs_n` goes low for exactly one clock, which is the last clock of a frame. The first clock after reset counts as such a last clock.
- R4: The first bit of timeslot 0 starts in the clock right after the `fs_n` pulse, so the data delay is zero. Bits go out MSB first on `tx_sd`, which changes only on falling edges. `rx_sd` is sampled on the rising edge that ends each bit. Each received byte is reported on `rx_data`, with `rx_slot` equal to its slot index from 0 to 127.
- R5: `tx_ready` is high only on the last clock of each timeslot. A byte that is valid on that clock is sent in the next timeslot.
- R6: If `tx_valid` is low when `tx_ready` is high, the next timeslot carries 8'hFF and `tx_underrun` goes to 1. It stays at 1 until reset.
- R7: Once `rx_valid` is set, it stays high and `rx_data`/`rx_slot` hold their values while `rx_ready` is low, until a newer byte completes.
- R8: A change on `mode_dbl` takes effect only for the frame that follows the next `fs_n` pulse. The frame in progress keeps its full length.
- R9: While reset is held, `fs_n`=1, `tx_sd`=1, `tx_ready`=0, `rx_valid`=0 and `tx_underrun`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock (16.384 MHz) |
| rst | input | 1 | Synchronous reset, active high |
| mode_dbl | input | 1 | 1 = two clocks per bit, 0 = one clock per bit |
| fs_n | output | 1 | Active-low frame sync, one clock per frame |
| tx_data | input | 8 | Byte for the next transmit timeslot |
| tx_valid | input | 1 | tx_data is available |
| tx_ready | output | 1 | Byte is taken at this clock edge |
| tx_sd | output | 1 | Serial transmit data, falling-edge launched |
| tx_underrun | output | 1 | Sticky: a timeslot was filled with all-ones |
| rx_sd | input | 1 | Serial receive data, rising-edge sampled |
| rx_data | output | 8 | Received byte |
| rx_slot | output | 7 | Timeslot index of rx_data |
| rx_valid | output | 1 | rx_data/rx_slot hold a new byte |
| rx_ready | input | 1 | Consumer takes the byte |

## Verification
The assertions assume that `mode_dbl` stays steady around each frame boundary. They also assume that `rx_ready` changes only between clock edges. With those held, mode switches can only happen where the frame counter wraps, and a held receive byte cannot change unless a new slot completes. The stimulus changes `mode_dbl` hundreds of clocks away from any sync pulse. It drives all inputs on falling edges and closes `tx_sd` back onto `rx_sd`. As a result, the received stream, the slot indices and the frame lengths all follow from the bytes the bench itself offered.

// File: rtl/tdm_link.sv
module tdm_link #(
  parameter int SLOTS     = 128,
  parameter int SLOT_BITS = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         mode_dbl,
  output logic                         fs_n,
  input  logic [SLOT_BITS-1:0]         tx_data,
  input  logic                         tx_valid,
  output logic                         tx_ready,
  output logic                         tx_sd,
  output logic                         tx_underrun,
  input  logic                         rx_sd,
  output logic [SLOT_BITS-1:0]         rx_data,
  output logic [$clog2(SLOTS)-1:0]     rx_slot,
  output logic                         rx_valid,
  input  logic                         rx_ready
);
  localparam int FBITS = SLOTS * SLOT_BITS;
  localparam int CW    = $clog2(FBITS);
  localparam int BW    = $clog2(SLOT_BITS);

  logic [CW-1:0]        bit_cnt;
  logic                 phase, mode_q;
  logic [SLOT_BITS-1:0] tx_sh, rx_sh;
  logic                 adv, slot_end, frame_end;

  assign adv       = !mode_q || phase;
  assign slot_end  = adv && (bit_cnt[BW-1:0] == '1);
  assign frame_end = adv && (bit_cnt == CW'(FBITS - 1));
  assign fs_n      = rst || !frame_end;
  assign tx_ready  = slot_end && !rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= CW'(FBITS - 1);
      phase   <= 1'b1;
      mode_q  <= mode_dbl;
    end else begin
      phase <= mode_q && !phase;
      if (adv) bit_cnt <= frame_end ? '0 : bit_cnt + 1'b1;
      if (frame_end) mode_q <= mode_dbl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh       <= '1;
      tx_underrun <= 1'b0;
    end else if (slot_end) begin
      tx_sh <= tx_valid ? tx_data : '1;
      if (!tx_valid) tx_underrun <= 1'b1;
    end else if (adv) begin
      tx_sh <= {tx_sh[SLOT_BITS-2:0], 1'b1};
    end
  end

  always_ff @(negedge clk) begin
    if (rst) tx_sd <= 1'b1;
    else     tx_sd <= tx_sh[SLOT_BITS-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sh    <= '0;
      rx_data  <= '0;
      rx_slot  <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (adv) rx_sh <= {rx_sh[SLOT_BITS-2:0], rx_sd};
      if (slot_end) begin
        rx_data  <= {rx_sh[SLOT_BITS-2:0], rx_sd};
        rx_slot  <= bit_cnt[CW-1:BW];
        rx_valid <= 1'b1;
      end else if (rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end

  // R3
  fs_single_clock_chk: assert property (@(posedge clk) disable iff (rst)
    !fs_n |=> fs_n);

  // R6
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    tx_underrun |=> tx_underrun);

  // R7
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready && !tx_ready) |=>
      (rx_valid && $stable(rx_data) && $stable(rx_slot)));

  // R8
  mode_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q != $past(mode_q)) |-> $past(!fs_n));

  // R5
  ready_at_slot_end_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ready |=> !tx_ready);
endmodule

// File: tb/tdm_link_tb_top.sv
module tdm_link_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_dbl = 1'b0;
  logic       fs_n, tx_ready, tx_sd, tx_underrun, rx_valid;
  logic [7:0] tx_data = 8'd5;
  logic       tx_valid = 1'b1;
  logic [7:0] rx_data;
  logic [6:0] rx_slot;
  logic       rx_ready = 1'b1;
  logic       go = 1'b0;
  int total = 0, bad = 0;
  logic [7:0] expq[$];

  always #4 clk = !clk;

  tdm_link dut_i (
    .clk(clk), .rst(rst), .mode_dbl(mode_dbl), .fs_n(fs_n),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_sd(tx_sd), .tx_underrun(tx_underrun), .rx_sd(tx_sd),
    .rx_data(rx_data), .rx_slot(rx_slot), .rx_valid(rx_valid),
    .rx_ready(rx_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int n);
    return 8'((n * 37 + 5) & 255);
  endfunction

  // transmit driver: R5, R6
  initial begin
    int n = 0;
    bit under_done = 1'b0;
    wait (go);
    forever begin
      if (tx_ready) begin
        if (n == 60 && !under_done) begin
          chk(tx_underrun == 1'b0, "R6 flag before", tx_underrun, 0);
          tx_valid = 1'b0;
          expq.push_back(8'hFF);
          @(posedge clk); #1;
          chk(tx_underrun == 1'b1, "R6 flag set", tx_underrun, 1);
          tx_valid = 1'b1;
          under_done = 1'b1;
        end else begin
          expq.push_back(tx_data);
          @(posedge clk); #1;
          n++;
          tx_data = pat(n);
        end
      end
      @(negedge clk); #1;
    end
  end

  // receive monitor: R4, R7
  initial begin
    int j = 0;
    int exp_slot = 0;
    logic [7:0] e;
    wait (go);
    forever begin
      @(negedge clk);
      if (rx_valid) begin
        if (j == 0) begin
          chk(rx_slot == 7'd127, "R4 first slot", rx_slot, 127);
        end else begin
          if (j == 20) begin
            rx_ready = 1'b0;
            for (int k = 0; k < 3; k++) begin
              logic [7:0] held;
              held = rx_data;
              @(negedge clk);
              chk(rx_valid && rx_data == held, "R7 hold", rx_data, held);
            end
            rx_ready = 1'b1;
          end
          e = (expq.size() > 0) ? expq.pop_front() : 8'h00;
          chk(rx_data == e, "R4 data", rx_data, e);
          chk(rx_slot == 7'(exp_slot), "R4 slot", rx_slot, exp_slot);
          exp_slot = (exp_slot + 1) % 128;
        end
        j++;
      end
    end
  end

  // frame sync monitor: R1, R2, R3, R8
  initial begin
    int cnt = 0;
    int exp_len = 0;
    bit seen = 1'b0;
    bit prev_low = 1'b0;
    wait (go);
    forever begin
      @(negedge clk);
      cnt++;
      if (!fs_n) begin
        chk(!prev_low, "R3 width", 2, 1);
        if (seen)
          chk(cnt == exp_len, exp_len == 2048 ? "R2/R8 period" : "R1/R8 period", cnt, exp_len);
        seen = 1'b1;
        cnt = 0;
        exp_len = mode_dbl ? 2048 : 1024;
      end
      prev_low = !fs_n;
    end
  end

  initial begin
    #(200000 * 8);
    chk(1'b0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    // R9
    chk(fs_n == 1'b1, "R9 fs_n", fs_n, 1);
    chk(tx_sd == 1'b1, "R9 tx_sd", tx_sd, 1);
    chk(tx_ready == 1'b0, "R9 tx_ready", tx_ready, 0);
    chk(rx_valid == 1'b0, "R9 rx_valid", rx_valid, 0);
    chk(tx_underrun == 1'b0, "R9 underrun", tx_underrun, 0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    go = 1'b1;
    repeat (3 * 1024 + 300) @(negedge clk);
    mode_dbl = 1'b1;
    repeat (3 * 2048) @(negedge clk);
    mode_dbl = 1'b0;
    repeat (2 * 1024 + 600) @(negedge clk);
    chk(tx_underrun == 1'b1, "R6 sticky", tx_underrun, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule